// File: doc/BRIEF.md
# Resampling Address Sequencer

This block drives the address side of an image resampler. A start pulse latches a set of bounds for the target coordinates u, v and (optionally) w. The block then visits every target pixel in raster order: u is the fastest coordinate, then v, then w. For each target pixel it walks a small source neighbourhood and emits one step per clock cycle. Each step carries a source pixel address, an address into an interpolation coefficient table, and accumulate controls for an external multiplier-accumulator. When the walk for a pixel has finished, the block issues a single-cycle write strobe that carries the target address.

The neighbourhood depends on the kernel mode: a single point for nearest, 2x2 for bilinear, and 4x4 for cubic. The 2x2 and 4x4 walks follow a spiral order. In single-axis mode the walk runs only along the u direction, which serves separable multi-pass filtering. The coordinate transform, the memories and the arithmetic sit outside the block. The source address is formed around the target location as {w, v+dy, u+dx}.

Top module: `rsmp_addr_seq`

## Requirements
- R1: After reset, busy, done, acc_valid, acc_clear and wr_en are all 0.
- R2: A start pulse taken while idle latches every bound and mode input, and busy reads 1 from the next cycle. A start pulse taken while busy is ignored: the output stream and the latched configuration stay unchanged.
- R3: Target pixels are visited with u running from u_min to u_max. When u reaches u_max it reloads u_min and v advances, until v reaches v_max. With three_d=1, w then advances from w_min to w_max. With three_d=0 only one plane is visited, and its w field equals w_min.
- R4: The number of walk steps per pixel is set by kmode: 0 gives 1 step, 1 (bilinear) gives 4 steps, 2 (cubic) gives 16 steps. Code 3 behaves as nearest and gives 1 step.
- R5: Steps are written as (dx,dy) offsets, with dy growing downward. The bilinear order is (0,0),(1,0),(1,1),(0,1). The cubic order is a clockwise inward spiral: (0,0),(1,0),(2,0),(3,0),(3,1),(3,2),(3,3),(2,3),(1,3),(0,3),(0,2),(0,1),(1,1),(2,1),(2,2),(1,2).
- R6: With single_axis=1, the bilinear walk has 2 steps and the cubic walk has 4. In this mode dx equals the step index and dy is 0.
- R7: src_addr is {w, (v+dy) mod 256, (u+dx) mod 256}. Bits 23:16 hold w, bits 15:8 hold the row, and bits 7:0 hold the column.
- R8: coef_addr is formed as follows: bits 11:7 are 0, bit 6 is single_axis, bits 5:4 are kmode, and bits 3:0 are the step index within the walk.
- R9: acc_valid is high for each walk step, and the steps of one walk occupy back-to-back cycles. acc_clear is high on the first step of each walk and on no other step.
- R10: wr_en is high for exactly one cycle, in the cycle right after the last step of a walk. During that cycle tgt_addr = {w, v, u}. The next walk begins in the following cycle.
- R11: After the write strobe of the final pixel, the next cycle shows done=1 and busy=0. done stays at 1 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; it latches the configuration when idle |
| kmode | input | 2 | Kernel mode: 0 nearest, 1 bilinear, 2 cubic, 3 nearest |
| single_axis | input | 1 | Walk along u only (separable pass) |
| three_d | input | 1 | Also step through w planes |
| u_min | input | CW | First u coordinate |
| u_max | input | CW | Last u coordinate |
| v_min | input | CW | First v coordinate |
| v_max | input | CW | Last v coordinate |
| w_min | input | CW | First w coordinate |
| w_max | input | CW | Last w coordinate |
| busy | output | 1 | A job is running |
| done | output | 1 | The last job has completed |
| acc_valid | output | 1 | Walk step valid, telling the accumulator to add |
| acc_clear | output | 1 | First step of a walk, telling the accumulator to restart |
| src_addr | output | 3*CW | Source pixel address |
| coef_addr | output | CAW | Coefficient table address |
| wr_en | output | 1 | Target write strobe |
| tgt_addr | output | 3*CW | Target pixel address |

## Verification
The hardest cases to reach from the ports are at the edges of the scan. These are the carries from u into v and from v into w on the final pixel, and the source column wrapping past 255 during a walk. Small bound windows reach them quickly. For example, u runs 254..255 for the wrap case, and a 2x2x2 volume exercises both carries. A second start pulse is also driven in the middle of a job with a different configuration. The scoreboard then confirms that the expected stream of the first job comes out unchanged and that busy stays high.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

  // 4x4 clockwise inward spiral: returns {dx, dy}
  function automatic logic [3:0] spiral16(input logic [3:0] s);
    logic [3:0] r;
    case (s)
      4'd0:  r = {2'd0, 2'd0};
      4'd1:  r = {2'd1, 2'd0};
      4'd2:  r = {2'd2, 2'd0};
      4'd3:  r = {2'd3, 2'd0};
      4'd4:  r = {2'd3, 2'd1};
      4'd5:  r = {2'd3, 2'd2};
      4'd6:  r = {2'd3, 2'd3};
      4'd7:  r = {2'd2, 2'd3};
      4'd8:  r = {2'd1, 2'd3};
      4'd9:  r = {2'd0, 2'd3};
      4'd10: r = {2'd0, 2'd2};
      4'd11: r = {2'd0, 2'd1};
      4'd12: r = {2'd1, 2'd1};
      4'd13: r = {2'd2, 2'd1};
      4'd14: r = {2'd2, 2'd2};
      default: r = {2'd1, 2'd2};
    endcase
    return r;
  endfunction

  // 2x2 loop: returns {dx, dy}
  function automatic logic [3:0] loop4(input logic [1:0] s);
    logic [3:0] r;
    case (s)
      2'd0: r = {2'd0, 2'd0};
      2'd1: r = {2'd1, 2'd0};
      2'd2: r = {2'd1, 2'd1};
      default: r = {2'd0, 2'd1};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rsmp_walk.sv
module rsmp_walk #(
  parameter int STW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  input  logic [1:0]     kmode,
  input  logic           single_axis,
  output logic [STW-1:0] step,
  output logic [1:0]     dx,
  output logic [1:0]     dy,
  output logic           is_last
);
  import rsmp_pkg::*;

  logic [STW-1:0] last_idx;
  logic [3:0]     off;

  always_comb begin
    case (kmode)
      2'd1:    last_idx = single_axis ? STW'(1) : STW'(3);
      2'd2:    last_idx = single_axis ? STW'(3) : STW'(15);
      default: last_idx = '0;
    endcase
  end

  assign is_last = (step == last_idx);

  always_comb begin
    if (single_axis)
      off = {step[1:0], 2'd0};
    else if (kmode == 2'd2)
      off = spiral16(step[3:0]);
    else if (kmode == 2'd1)
      off = loop4(step[1:0]);
    else
      off = 4'd0;
  end

  assign dx = off[3:2];
  assign dy = off[1:0];

  always_ff @(posedge clk) begin
    if (rst || load)
      step <= '0;
    else if (adv)
      step <= is_last ? '0 : step + 1'b1;
  end
endmodule

// File: rtl/rsmp_scan.sv
module rsmp_scan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic          three_d,
  input  logic [CW-1:0] u_lo,
  input  logic [CW-1:0] u_hi,
  input  logic [CW-1:0] v_lo,
  input  logic [CW-1:0] v_hi,
  input  logic [CW-1:0] w_lo,
  input  logic [CW-1:0] w_hi,
  output logic [CW-1:0] u,
  output logic [CW-1:0] v,
  output logic [CW-1:0] w,
  output logic          last_pix
);
  logic [CW-1:0] umin_q, umax_q, vmin_q, vmax_q, wmax_q;
  logic          u_end, v_end, w_end;

  assign u_end    = (u == umax_q);
  assign v_end    = (v == vmax_q);
  assign w_end    = !three_d || (w == wmax_q);
  assign last_pix = u_end && v_end && w_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      umin_q <= '0; umax_q <= '0; vmin_q <= '0; vmax_q <= '0; wmax_q <= '0;
      u <= '0; v <= '0; w <= '0;
    end else if (load) begin
      umin_q <= u_lo; umax_q <= u_hi;
      vmin_q <= v_lo; vmax_q <= v_hi;
      wmax_q <= w_hi;
      u <= u_lo; v <= v_lo; w <= w_lo;
    end else if (adv) begin
      if (!u_end) begin
        u <= u + 1'b1;
      end else begin
        u <= umin_q;
        if (!v_end) begin
          v <= v + 1'b1;
        end else begin
          v <= vmin_q;
          if (!w_end) w <= w + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsmp_addr_seq.sv
module rsmp_addr_seq #(
  parameter int CW  = 8,
  parameter int CAW = 12,
  parameter int STW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        kmode,
  input  logic              single_axis,
  input  logic              three_d,
  input  logic [CW-1:0]     u_min,
  input  logic [CW-1:0]     u_max,
  input  logic [CW-1:0]     v_min,
  input  logic [CW-1:0]     v_max,
  input  logic [CW-1:0]     w_min,
  input  logic [CW-1:0]     w_max,
  output logic              busy,
  output logic              done,
  output logic              acc_valid,
  output logic              acc_clear,
  output logic [3*CW-1:0]   src_addr,
  output logic [CAW-1:0]    coef_addr,
  output logic              wr_en,
  output logic [3*CW-1:0]   tgt_addr
);
  import rsmp_pkg::*;

  localparam int KFW = CAW - STW;

  seq_state_e     state;
  logic [1:0]     kmode_q;
  logic           sa_q, td_q;
  logic           go, walk_adv, scan_adv;
  logic [STW-1:0] step;
  logic [1:0]     dx, dy;
  logic           step_last, pix_last;
  logic [CW-1:0]  u, v, w;
  logic [KFW-1:0] kfield;

  assign go       = start && (state == ST_IDLE);
  assign walk_adv = (state == ST_WALK);
  assign scan_adv = (state == ST_WR);
  assign kfield   = KFW'({sa_q, kmode_q});

  rsmp_walk #(.STW(STW)) u_walk (
    .clk(clk), .rst(rst), .load(go), .adv(walk_adv),
    .kmode(kmode_q), .single_axis(sa_q),
    .step(step), .dx(dx), .dy(dy), .is_last(step_last)
  );

  rsmp_scan #(.CW(CW)) u_scan (
    .clk(clk), .rst(rst), .load(go), .adv(scan_adv), .three_d(td_q),
    .u_lo(u_min), .u_hi(u_max), .v_lo(v_min), .v_hi(v_max),
    .w_lo(w_min), .w_hi(w_max),
    .u(u), .v(v), .w(w), .last_pix(pix_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kmode_q   <= '0;
      sa_q      <= 1'b0;
      td_q      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      acc_valid <= 1'b0;
      acc_clear <= 1'b0;
      wr_en     <= 1'b0;
      src_addr  <= '0;
      coef_addr <= '0;
      tgt_addr  <= '0;
    end else begin
      acc_valid <= 1'b0;
      acc_clear <= 1'b0;
      wr_en     <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          kmode_q <= kmode;
          sa_q    <= single_axis;
          td_q    <= three_d;
          busy    <= 1'b1;
          done    <= 1'b0;
          state   <= ST_WALK;
        end
        ST_WALK: begin
          acc_valid <= 1'b1;
          acc_clear <= (step == '0);
          src_addr  <= {w, v + CW'(dy), u + CW'(dx)};
          coef_addr <= {kfield, step};
          if (step_last) state <= ST_WR;
        end
        ST_WR: begin
          wr_en    <= 1'b1;
          tgt_addr <= {w, v, u};
          state    <= pix_last ? ST_FIN : ST_WALK;
        end
        default: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsmp_addr_seq_chk.sv
module rsmp_addr_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic acc_valid,
  input logic acc_clear,
  input logic wr_en
);
  // R10: a write strobe directly follows a walk step
  p_wr_after_step_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(acc_valid));

  // R10: strobe and walk step never overlap
  p_wr_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && acc_valid));

  // R9: clear only accompanies a valid step
  p_clear_valid_r9: assert property (@(posedge clk) disable iff (rst)
    acc_clear |-> acc_valid);

  // R9: every walk opens with a clear
  p_clear_first_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !$past(acc_valid)) |-> acc_clear);

  // R11: done and busy are never both high
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: nothing is issued once done
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!acc_valid && !wr_en));

  // R11: done rises only right after a write strobe
  p_done_after_wr_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(wr_en));
endmodule

bind rsmp_addr_seq rsmp_addr_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .acc_valid(acc_valid), .acc_clear(acc_clear), .wr_en(wr_en)
);

// File: tb/rsmp_addr_seq_test.sv
module rsmp_addr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int CAW = 12;
  localparam int AW  = 3 * CW;

  typedef struct packed {
    logic          wr;
    logic          clr;
    logic [AW-1:0] a;
    logic [CAW-1:0] c;
  } item_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] kmode = '0;
  logic single_axis = 1'b0, three_d = 1'b0;
  logic [CW-1:0] u_min = '0, u_max = '0, v_min = '0, v_max = '0, w_min = '0, w_max = '0;
  logic busy, done, acc_valid, acc_clear, wr_en;
  logic [AW-1:0] src_addr, tgt_addr;
  logic [CAW-1:0] coef_addr;

  int checks = 0, fails = 0;
  item_t exp_q[$];
  logic prev_acc = 1'b0, prev_wr = 1'b0, cur_wr = 1'b0;
  bit finished = 0;

  // offsets from the requirement R5 tables: index = step
  int sp_dx[16] = '{0,1,2,3,3,3,3,2,1,0,0,0,1,2,2,1};
  int sp_dy[16] = '{0,0,0,0,1,2,3,3,3,3,2,1,1,1,2,2};
  int bl_dx[4]  = '{0,1,1,0};
  int bl_dy[4]  = '{0,0,1,1};

  always #(CLK_PERIOD/2) clk = ~clk;

  rsmp_addr_seq uut (
    .clk(clk), .rst(rst), .start(start), .kmode(kmode),
    .single_axis(single_axis), .three_d(three_d),
    .u_min(u_min), .u_max(u_max), .v_min(v_min), .v_max(v_max),
    .w_min(w_min), .w_max(w_max),
    .busy(busy), .done(done), .acc_valid(acc_valid), .acc_clear(acc_clear),
    .src_addr(src_addr), .coef_addr(coef_addr), .wr_en(wr_en), .tgt_addr(tgt_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_valid || wr_en) begin
        item_t got, e;
        got.wr  = wr_en;
        got.clr = acc_clear;
        got.a   = wr_en ? tgt_addr : src_addr;
        got.c   = wr_en ? '0 : coef_addr;
        if (exp_q.size() == 0) begin
          check(0, "R2/R3", "unexpected output item", 64'(got), 64'h0);
        end else begin
          e = exp_q.pop_front();
          check(got == e, e.wr ? "R3/R10" : "R5/R7/R8/R9", "stream item",
                64'(got), 64'(e));
        end
        if (wr_en) check(prev_acc && !acc_valid, "R10", "strobe after last step",
                         64'({prev_acc, acc_valid}), 64'b10);
      end
      prev_acc = acc_valid;
      prev_wr  = cur_wr;
      cur_wr   = wr_en;
    end
  end

  task automatic push_job(input int km, input bit sa, input bit td,
                          input int ul, input int uh, input int vl, input int vh,
                          input int wl, input int wh);
    int n;
    int wend;
    if (km == 1) n = sa ? 2 : 4;
    else if (km == 2) n = sa ? 4 : 16;
    else n = 1;
    wend = td ? wh : wl;
    for (int w = wl; w <= wend; w++)
      for (int v = vl; v <= vh; v++)
        for (int u = ul; u <= uh; u++) begin
          for (int s = 0; s < n; s++) begin
            item_t it;
            int dx, dy;
            if (sa) begin dx = s; dy = 0; end
            else if (km == 2) begin dx = sp_dx[s]; dy = sp_dy[s]; end
            else if (km == 1) begin dx = bl_dx[s]; dy = bl_dy[s]; end
            else begin dx = 0; dy = 0; end
            it.wr  = 1'b0;
            it.clr = (s == 0);
            it.a   = {8'(w), 8'(v + dy), 8'(u + dx)};
            it.c   = {5'b0, sa, 2'(km), 4'(s)};
            exp_q.push_back(it);
          end
          begin
            item_t wi;
            wi.wr = 1'b1; wi.clr = 1'b0;
            wi.a = {8'(w), 8'(v), 8'(u)};
            wi.c = '0;
            exp_q.push_back(wi);
          end
        end
  endtask

  task automatic run_job(input string req, input int km, input bit sa, input bit td,
                         input int ul, input int uh, input int vl, input int vh,
                         input int wl, input int wh, input bit poke);
    push_job(km, sa, td, ul, uh, vl, vh, wl, wh);
    @(negedge clk);
    kmode = 2'(km); single_axis = sa; three_d = td;
    u_min = 8'(ul); u_max = 8'(uh); v_min = 8'(vl); v_max = 8'(vh);
    w_min = 8'(wl); w_max = 8'(wh);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 check(busy && !done, "R2", "busy after start", 64'({busy, done}), 64'b10);
    if (poke) begin
      repeat (3) @(negedge clk);
      kmode = 2'd2; single_axis = 1'b0; three_d = 1'b1;
      u_min = 8'd90; u_max = 8'd99; w_max = 8'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1 check(busy, "R2", "busy kept after ignored start", 64'(busy), 64'd1);
    end
    while (!done) @(negedge clk);
    #1;
    check(prev_wr && !busy, "R11", "done right after final strobe",
          64'({prev_wr, busy}), 64'b10);
    check(exp_q.size() == 0, req, "all expected items emitted",
          64'(exp_q.size()), 64'd0);
    exp_q.delete();
    repeat (2) @(negedge clk);
    #1 check(done && !busy, "R11", "done held", 64'({done, busy}), 64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check({busy, done, acc_valid, acc_clear, wr_en} == 5'b0, "R1", "reset state",
             64'({busy, done, acc_valid, acc_clear, wr_en}), 64'd0);
    rst = 1'b0;
    // R3 R4: nearest, 2-D raster with u/v carries
    run_job("R3", 0, 0, 0, 3, 5, 1, 2, 7, 9, 0);
    // R5 R3: bilinear, 3-D volume 2x2x2
    run_job("R5", 1, 0, 1, 0, 1, 0, 1, 2, 3, 0);
    // R5 R8: cubic spiral, single pixel
    run_job("R5", 2, 0, 0, 10, 10, 5, 5, 0, 0, 0);
    // R6 R7: single-axis cubic with column wrap
    run_job("R6", 2, 1, 0, 254, 255, 0, 0, 4, 4, 0);
    // R6 R2: single-axis bilinear with an ignored start mid-job
    run_job("R2", 1, 1, 0, 20, 23, 3, 4, 1, 1, 1);
    // R4: code 3 behaves as nearest
    run_job("R4", 3, 0, 1, 7, 8, 7, 7, 0, 1, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule